// File: doc/BRIEF.md
# Up/Down Wiper Counter Controller

This block keeps four 8-bit wiper position counters and moves them from a simple pulse interface. An external host pulls a chip-select pin low, picks a channel with two select pins and a direction with a direction pin, and then toggles a step pin. Each falling edge of the step pin moves the selected counter by one position. When the host releases chip select, the block decides whether to keep the new position only in the counter or also to commit it to that channel's slot-0 storage register. Storage is modelled here as plain registers.

All pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser before any edge is detected. While chip select is low, a flag tells the neighbouring serial bus logic to stay disabled. A committed store starts a busy timer that stands in for the slow storage write. Further stores are refused until the timer runs out. A 2-bit status input carries the shared status register's data-register-select field. A store is allowed only when that field is zero.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: After reset every counter and every slot-0 register holds RESET_CODE (0x80 by default), busy is 0 and bus_disable is 0.
- R2: While chip select (cs_n_pin) is low, each high-to-low transition of step_pin moves the selected counter by exactly one. It moves up when dir_pin is 1 and down when dir_pin is 0. The change is visible within 3 clock cycles of the synchronised edge.
- R3: While cs_n_pin is high, step_pin transitions leave every counter unchanged.
- R4: sel_pin picks the channel by its binary value: 0 selects channel 0, 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3. The counter for channel i sits at wiper_flat[8*i+7:8*i]. Other counters do not move.
- R5: A counter saturates. It stays at 0x00 on a down step and at 0xFF on an up step. It never wraps.
- R6: A store happens when cs_n_pin rises while step_pin is 1, wp_pin is 1, status_dsel is 0 and busy is 0. The store copies the selected counter into that channel's slot-0 register at slot_flat[8*i+7:8*i].
- R7: No store happens if cs_n_pin rises while step_pin is 0 or while wp_pin is 0. The counter keeps its new value.
- R8: No store happens when status_dsel is non-zero at the moment cs_n_pin rises.
- R9: A store raises busy for BUSY_CYCLES clock cycles. Any store request made while busy is 1 is ignored.
- R10: bus_disable is 1 exactly while the synchronised cs_n_pin is low, two clock cycles behind the pin.
- R11: dir_pin and sel_pin may change between steps while chip select stays low. Each step uses the values present at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_pin | input | 1 | Active-low chip select, asynchronous |
| step_pin | input | 1 | Step clock pin; a falling edge moves the selected counter |
| dir_pin | input | 1 | Direction: 1 up, 0 down |
| sel_pin | input | 2 | Channel select |
| wp_pin | input | 1 | Write permit; a store requires 1 |
| status_dsel | input | 2 | Data-register-select field of the shared status register |
| wiper_flat | output | 32 | Four packed wiper counters, channel 0 in the low byte |
| slot_flat | output | 32 | Four packed slot-0 storage registers |
| busy | output | 1 | Storage write in progress |
| bus_disable | output | 1 | Holds the serial bus interface off |

## Verification
The bench builds the block with BUSY_CYCLES set to 40 instead of the full-length default. This makes the whole busy window short enough to observe. The bench issues a refused second store inside the window, then watches busy fall and a later store succeed. The other parameters keep their defaults, so four channels and 8-bit counters are exercised. That makes saturation at both ends reachable with a few hundred steps. Randomised step, select and deselect sequences, under every combination of step level, write permit and select field, run alongside directed cases.

// File: rtl/updown_wiper_ctrl.sv
module updown_wiper_ctrl #(
  parameter int CH          = 4,
  parameter int W           = 8,
  parameter int BUSY_CYCLES = 1250000,
  parameter int RESET_CODE  = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n_pin,
  input  logic                      step_pin,
  input  logic                      dir_pin,
  input  logic [$clog2(CH)-1:0]     sel_pin,
  input  logic                      wp_pin,
  input  logic [1:0]                status_dsel,
  output logic [CH*W-1:0]           wiper_flat,
  output logic [CH*W-1:0]           slot_flat,
  output logic                      busy,
  output logic                      bus_disable
);
  localparam int SEL_W  = $clog2(CH);
  localparam int PW     = 4 + SEL_W;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] INIT = W'(RESET_CODE);
  localparam logic [PW-1:0] IDLE = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] raw, meta, sync;
  logic cs_prev, step_prev;
  logic [BUSY_W-1:0] busy_cnt;

  assign raw = {cs_n_pin, step_pin, dir_pin, wp_pin, sel_pin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta      <= IDLE;
      sync      <= IDLE;
      cs_prev   <= 1'b1;
      step_prev <= 1'b0;
    end else begin
      meta      <= raw;
      sync      <= meta;
      cs_prev   <= sync[PW-1];
      step_prev <= sync[PW-2];
    end
  end

  wire             cs_s   = sync[PW-1];
  wire             step_s = sync[PW-2];
  wire             dir_s  = sync[PW-3];
  wire             wp_s   = sync[PW-4];
  wire [SEL_W-1:0] sel_s  = sync[SEL_W-1:0];

  wire move     = step_prev & ~step_s & ~cs_s;
  wire store_go = cs_s & ~cs_prev & step_s & wp_s
                & (status_dsel == 2'b00) & (busy_cnt == '0);

  assign busy        = (busy_cnt != '0);
  assign bus_disable = ~cs_s;

  always_ff @(posedge clk) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (store_go)       busy_cnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [W-1:0] cnt, slot;
    wire hit = (sel_s == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= INIT;
        slot <= INIT;
      end else begin
        if (move && hit) begin
          if (dir_s && cnt != TOP)       cnt <= cnt + 1'b1;
          else if (!dir_s && cnt != '0)  cnt <= cnt - 1'b1;
        end
        if (store_go && hit) slot <= cnt;
      end
    end

    assign wiper_flat[i*W +: W] = cnt;
    assign slot_flat[i*W +: W]  = slot;
  end
endmodule

// File: rtl/updown_wiper_ctrl_chk.sv
module updown_wiper_ctrl_chk #(
  parameter int CH = 4,
  parameter int W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n_pin,
  input logic [CH*W-1:0] wiper_flat,
  input logic [CH*W-1:0] slot_flat,
  input logic            busy,
  input logic            bus_disable
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_bus_follows_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (bus_disable == !$past(cs_n_pin, 2)));

  p_store_arms_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_flat != $past(slot_flat)) |-> (busy && !$past(busy)));

  for (genvar i = 0; i < CH; i++) begin : g_a
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_flat[i*W +: W] != $past(wiper_flat[i*W +: W])) |->
      ((wiper_flat[i*W +: W] == $past(wiper_flat[i*W +: W]) + W'(1)) ||
       (wiper_flat[i*W +: W] == $past(wiper_flat[i*W +: W]) - W'(1))));

    p_still_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_flat[i*W +: W] != $past(wiper_flat[i*W +: W])) |-> $past(bus_disable));

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(($past(wiper_flat[i*W +: W]) == {W{1'b1}}) && (wiper_flat[i*W +: W] == '0)) &&
      !(($past(wiper_flat[i*W +: W]) == '0) && (wiper_flat[i*W +: W] == {W{1'b1}})));
  end
endmodule

bind updown_wiper_ctrl updown_wiper_ctrl_chk #(.CH(CH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .wiper_flat(wiper_flat),
  .slot_flat(slot_flat), .busy(busy), .bus_disable(bus_disable)
);

// File: tb/tb_updown_wiper_ctrl.sv
module tb_updown_wiper_ctrl;
  localparam int BUSY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, step_pin = 1'b0, dir_pin = 1'b0, wp_pin = 1'b0;
  logic [1:0] sel_pin = 2'd0, status_dsel = 2'd0;
  logic [31:0] wiper_flat, slot_flat;
  logic busy, bus_disable;

  int total = 0, bad = 0;
  logic [7:0] exp_w [4];
  logic [7:0] exp_s [4];

  always #4 clk = ~clk;

  updown_wiper_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .step_pin(step_pin),
    .dir_pin(dir_pin), .sel_pin(sel_pin), .wp_pin(wp_pin),
    .status_dsel(status_dsel), .wiper_flat(wiper_flat), .slot_flat(slot_flat),
    .busy(busy), .bus_disable(bus_disable)
  );

  function automatic logic [7:0] f_step(input logic [7:0] v, input logic up);
    if (up)  return (v == 8'hFF) ? v : v + 8'd1;
    else     return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  function automatic logic f_store(input logic lvl, input logic wp, input logic [1:0] ds);
    return lvl && wp && (ds == 2'd0);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk({tag, " wiper"}, 32'(wiper_flat[c*8 +: 8]), 32'(exp_w[c]));
      chk({tag, " slot"},  32'(slot_flat[c*8 +: 8]),  32'(exp_s[c]));
    end
  endtask

  task automatic select_dev();
    cs_n_pin = 1'b0; tick(5);
  endtask

  task automatic step(input logic [1:0] ch, input logic up);
    sel_pin = ch; dir_pin = up; tick(2);
    step_pin = 1'b1; tick(5);
    step_pin = 1'b0; tick(5);
    if (!cs_n_pin) exp_w[ch] = f_step(exp_w[ch], up);
  endtask

  task automatic deselect(input logic lvl, input logic wp, input logic [1:0] ds, input logic allow);
    step_pin = lvl; wp_pin = wp; status_dsel = ds; tick(5);
    cs_n_pin = 1'b1; tick(5);
    if (allow && f_store(lvl, wp, ds)) exp_s[sel_pin] = exp_w[sel_pin];
    step_pin = 1'b0; tick(5);
  endtask

  initial begin
    tick(200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < 4; c++) begin exp_w[c] = 8'h80; exp_s[c] = 8'h80; end
    tick(4); rst_n = 1'b1; tick(2);

    check_all("R1 reset");
    chk("R1 busy", 32'(busy), 0);
    chk("R1 bus_disable", 32'(bus_disable), 0);

    select_dev();
    chk("R10 bus off while selected", 32'(bus_disable), 1);
    step(0, 1); step(0, 1); step(0, 1);
    check_all("R2 up steps");
    step(0, 0);
    check_all("R2 R11 dir change");
    step(2, 1);
    check_all("R4 R11 sel change");
    deselect(1'b0, 1'b0, 2'd0, 1'b1);
    chk("R10 bus released", 32'(bus_disable), 0);

    step(1, 1); step(3, 0);
    check_all("R3 ignored while deselected");

    select_dev();
    step(1, 1); step(1, 1);
    deselect(1'b1, 1'b1, 2'd0, 1'b1);
    check_all("R6 store");
    chk("R9 busy after store", 32'(busy), 1);
    tick(BUSY + 5);
    chk("R9 busy expired", 32'(busy), 0);

    select_dev(); step(1, 1);
    deselect(1'b0, 1'b1, 2'd0, 1'b1);
    check_all("R7 step low no store");
    select_dev(); step(1, 1);
    deselect(1'b1, 1'b0, 2'd0, 1'b1);
    check_all("R7 wp low no store");
    select_dev(); step(1, 1);
    deselect(1'b1, 1'b1, 2'd2, 1'b1);
    check_all("R8 dsel nonzero no store");
    chk("R8 busy idle", 32'(busy), 0);

    select_dev(); step(3, 1);
    deselect(1'b1, 1'b1, 2'd0, 1'b1);
    select_dev(); step(3, 1);
    deselect(1'b1, 1'b1, 2'd0, 1'b0);
    check_all("R9 store ignored while busy");
    tick(BUSY + 5);
    select_dev();
    deselect(1'b1, 1'b1, 2'd0, 1'b1);
    check_all("R9 store after expiry");
    tick(BUSY + 5);

    select_dev();
    for (int k = 0; k < 140; k++) step(0, 0);
    check_all("R5 floor");
    for (int k = 0; k < 260; k++) step(0, 1);
    check_all("R5 ceiling");
    deselect(1'b0, 1'b0, 2'd0, 1'b1);

    select_dev();
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 5) != 0) begin
        step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        check_all("R2 R4 R11 random step");
      end else begin
        deselect(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), 1'b1);
        check_all("R6 R7 R8 random deselect");
        tick(BUSY + 5);
        select_dev();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule